// File: doc/BRIEF.md
# IO Transfer Fault Monitor

This block sits on the CPU side of a group of memory-mapped peripherals whose read buses are merged by a plain OR. Each CPU request into IO space is checked, passed to the peripherals as a single-cycle strobe, and then followed until it ends in one of three ways. It ends in a normal completion when any peripheral pulses acknowledge. It ends in an immediate fault when a write has an illegal size or a peripheral pulses error. It ends in a timeout fault when nothing answers within a set number of cycles. The CPU sees exactly one single-cycle response per request: `rsp_done` or `rsp_fault`.

The controller is a four-state machine. In `ST_IDLE` it takes a new request. It moves to `ST_WAIT` when the request is legal and is forwarded (transition *accept*). It moves to `ST_FAULT` when the request is a write narrower than a word (transition *size_reject*). In `ST_WAIT` it moves to `ST_FAULT` on any error pulse (transition *err_hit*, which takes priority) or when the wait counter expires (transition *timeout*). It moves to `ST_DONE` on any acknowledge pulse (transition *ack_hit*). `ST_DONE` and `ST_FAULT` each last one cycle and always return to `ST_IDLE` (transition *retire*). A completed read returns the OR of all peripheral read buses, captured in the acknowledge cycle.

Top module: `iofault_monitor`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `rsp_done`, `rsp_fault`, `rsp_rdata`, `per_rd` and `per_wr` are all zero. A request in the first cycle after reset is accepted.
- R2: A legal request in `ST_IDLE` is forwarded combinationally in the same cycle: `per_rd` for a read, `per_wr` for a write. `per_addr` and `per_wdata` equal the request fields. Reads of any size are legal.
- R3: Sizes are encoded as 0 byte, 1 half-word, 2 word, 3 reserved. A write whose `req_size` is not 2 is not forwarded (`per_wr` stays 0), and `rsp_fault` is high in the next cycle.
- R4: When any `per_ack` bit is high in a waiting cycle and no `per_err` bit is high, `rsp_done` is high for exactly the following cycle.
- R5: During `rsp_done` after a read, `rsp_rdata` equals the bitwise OR of all `per_rdata` slices as sampled in the acknowledge cycle. It is zero after a write and at every other time.
- R6: When any `per_err` bit is high in a waiting cycle, `rsp_fault` is high in the following cycle, even if an acknowledge arrives at the same time.
- R7: With the default limit of 15, a request answered by nothing produces `rsp_fault` in cycle 16 after the request cycle. An acknowledge in waiting cycle 15 still completes normally.
- R8: The wait counter restarts at zero for every accepted request. A transfer that follows a timed-out transfer gets the full window.
- R9: `per_ack` and `per_err` pulses while no transfer is outstanding produce no response.
- R10: Each request yields exactly one response cycle, never `rsp_done` and `rsp_fault` together. Requests presented outside `ST_IDLE` are neither forwarded nor answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rd | input | 1 | CPU read request pulse |
| req_wr | input | 1 | CPU write request pulse |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| req_addr | input | AW (32) | Request address |
| req_wdata | input | DW (32) | Write data |
| rsp_done | output | 1 | Normal completion pulse |
| rsp_fault | output | 1 | Access fault pulse |
| rsp_rdata | output | DW (32) | Read data, valid with `rsp_done` |
| per_rd | output | 1 | Read strobe to peripherals |
| per_wr | output | 1 | Write strobe to peripherals |
| per_addr | output | AW (32) | Address to peripherals |
| per_wdata | output | DW (32) | Write data to peripherals |
| per_ack | input | NPER (4) | Acknowledge pulse, one bit per peripheral |
| per_err | input | NPER (4) | Error pulse, one bit per peripheral |
| per_rdata | input | NPER*DW (128) | Peripheral read buses, one slice each |

## Verification
The assertions assume that the CPU never raises `req_rd` and `req_wr` together. They also assume that it waits for a response before it issues the next request. Peripherals are assumed to drive zero on their read buses except in the cycle they acknowledge. The stimulus holds each request for one cycle and drives acknowledge, error and read data only in a single chosen waiting cycle, clearing them in the next. The one deliberate breach is a request presented while a transfer is in flight, and it is used to show that such a request is dropped.

// File: rtl/iofm_pkg.sv
package iofm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } iofm_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } iofm_size_e;

endpackage

// File: rtl/iofm_size_check.sv
module iofm_size_check
    import iofm_pkg::*;
(
    input  logic       is_write,
    input  logic [1:0] size,
    output logic       legal
);
    // only full-word stores may enter IO space; loads of any width pass
    always_comb begin
        legal = !is_write || (size == SZ_WORD);
    end

    always_comb begin
        assert_reject_narrow_R3: assert (!(is_write && size == SZ_BYTE) || !legal);
    end
endmodule

// File: rtl/iofm_resp_merge.sv
module iofm_resp_merge #(
    parameter int NPER = 4,
    parameter int DW   = 32
) (
    input  logic [NPER-1:0]    ack_vec,
    input  logic [NPER-1:0]    err_vec,
    input  logic [NPER*DW-1:0] rdata_flat,
    output logic               ack_any,
    output logic               err_any,
    output logic [DW-1:0]      rdata_or
);
    logic [DW-1:0] partial [NPER+1];

    assign partial[0] = '0;

    generate
        for (genvar g = 0; g < NPER; g++) begin : g_or
            assign partial[g+1] = partial[g] | rdata_flat[g*DW +: DW];
        end
    endgenerate

    assign rdata_or = partial[NPER];
    assign ack_any  = |ack_vec;
    assign err_any  = |err_vec;
endmodule

// File: rtl/iofm_wait_timer.sv
module iofm_wait_timer #(
    parameter int TIMEOUT = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    assert_clear_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));
endmodule

// File: rtl/iofault_monitor.sv
module iofault_monitor
    import iofm_pkg::*;
#(
    parameter int NPER    = 4,
    parameter int DW      = 32,
    parameter int AW      = 32,
    parameter int TIMEOUT = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_rd,
    input  logic               req_wr,
    input  logic [1:0]         req_size,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               rsp_done,
    output logic               rsp_fault,
    output logic [DW-1:0]      rsp_rdata,
    output logic               per_rd,
    output logic               per_wr,
    output logic [AW-1:0]      per_addr,
    output logic [DW-1:0]      per_wdata,
    input  logic [NPER-1:0]    per_ack,
    input  logic [NPER-1:0]    per_err,
    input  logic [NPER*DW-1:0] per_rdata
);
    iofm_state_e state, state_nx;

    logic          size_ok;
    logic          ack_any, err_any;
    logic [DW-1:0] rdata_or;
    logic          accept, timer_run, expired;
    logic          is_read_q;
    logic [DW-1:0] rdata_q;

    iofm_size_check u_size (
        .is_write (req_wr),
        .size     (req_size),
        .legal    (size_ok)
    );

    iofm_resp_merge #(.NPER(NPER), .DW(DW)) u_merge (
        .ack_vec    (per_ack),
        .err_vec    (per_err),
        .rdata_flat (per_rdata),
        .ack_any    (ack_any),
        .err_any    (err_any),
        .rdata_or   (rdata_or)
    );

    assign accept    = (state == ST_IDLE) && (req_rd || req_wr);
    assign timer_run = (state == ST_WAIT) && !ack_any && !err_any;

    iofm_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .run     (timer_run),
        .expired (expired)
    );

    // forward strobes to the peripherals in the request cycle
    assign per_rd    = accept && req_rd && !req_wr;
    assign per_wr    = accept && req_wr && size_ok;
    assign per_addr  = req_addr;
    assign per_wdata = req_wdata;

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_nx = size_ok ? ST_WAIT : ST_FAULT;
                end
            end
            ST_WAIT: begin
                if (err_any) begin
                    state_nx = ST_FAULT;
                end else if (ack_any) begin
                    state_nx = ST_DONE;
                end else if (expired) begin
                    state_nx = ST_FAULT;
                end
            end
            ST_DONE:  state_nx = ST_IDLE;
            ST_FAULT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // output registers: read data capture and transfer direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_read_q <= 1'b0;
            rdata_q   <= '0;
        end else begin
            if (accept) begin
                is_read_q <= !req_wr;
            end
            if (state == ST_WAIT && ack_any && !err_any && is_read_q) begin
                rdata_q <= rdata_or;
            end else begin
                rdata_q <= '0;
            end
        end
    end

    assign rsp_done  = (state == ST_DONE);
    assign rsp_fault = (state == ST_FAULT);
    assign rsp_rdata = rdata_q;

    assert_narrow_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && req_size != SZ_WORD) |-> !per_wr);

    assert_narrow_faults_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_wr && req_size != SZ_WORD) |=> rsp_fault);

    assert_ack_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && ack_any && !err_any) |=> rsp_done);

    assert_rdata_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_rdata != '0) |-> rsp_done);

    assert_err_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && err_any) |=> rsp_fault);

    assert_idle_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !req_rd && !req_wr) |=> (!rsp_done && !rsp_fault));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done || rsp_fault) |=> (!rsp_done && !rsp_fault));

    assert_busy_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (!per_rd && !per_wr));
endmodule

// File: tb/iofault_monitor_bench.sv
module iofault_monitor_bench;
    localparam int NPER = 4;
    localparam int DW   = 32;
    localparam int AW   = 32;
    localparam int TMO  = 15;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_rd = 1'b0, req_wr = 1'b0;
    logic [1:0]         req_size = 2'd2;
    logic [AW-1:0]      req_addr = '0;
    logic [DW-1:0]      req_wdata = '0;
    logic               rsp_done, rsp_fault;
    logic [DW-1:0]      rsp_rdata;
    logic               per_rd, per_wr;
    logic [AW-1:0]      per_addr;
    logic [DW-1:0]      per_wdata;
    logic [NPER-1:0]    per_ack = '0, per_err = '0;
    logic [NPER*DW-1:0] per_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    iofault_monitor #(.NPER(NPER), .DW(DW), .AW(AW), .TIMEOUT(TMO)) u_iofault_monitor (
        .clk(clk), .rst_n(rst_n),
        .req_rd(req_rd), .req_wr(req_wr), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
        .per_rd(per_rd), .per_wr(per_wr), .per_addr(per_addr), .per_wdata(per_wdata),
        .per_ack(per_ack), .per_err(per_err), .per_rdata(per_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] or_slices(input logic [NPER*DW-1:0] v);
        logic [DW-1:0] r = '0;
        for (int i = 0; i < NPER; i++) r = r | v[i*DW +: DW];
        return r;
    endfunction

    function automatic logic [1:0] resp_code(input logic d, input logic f);
        return {d, f};
    endfunction

    task automatic quiet(input string tag);
        chk(!rsp_done && !rsp_fault && rsp_rdata == '0, tag,
            {rsp_done, rsp_fault, rsp_rdata}, 64'd0);
    endtask

    // kind: 0 ack, 1 err, 2 nothing (timeout), 3 ack and err together
    task automatic xfer(input bit isrd, input logic [1:0] sz, input int kind, input int lat);
        logic [NPER*DW-1:0] d;
        logic [AW-1:0] a;
        logic [DW-1:0] w;
        bit legal;
        int who;
        d = {$urandom, $urandom, $urandom, $urandom};
        a = $urandom;
        w = $urandom;
        legal = isrd || (sz == 2'd2);
        who = $urandom_range(NPER - 1, 0);
        @(negedge clk);
        req_rd = isrd; req_wr = !isrd; req_size = sz; req_addr = a; req_wdata = w;
        #1;
        chk(per_rd == isrd, "R2 read strobe", per_rd, isrd);
        chk(per_wr == (!isrd && legal), legal ? "R2 write strobe" : "R3 narrow write blocked",
            per_wr, !isrd && legal);
        if (legal) chk(per_addr == a && per_wdata == w, "R2 pass-through",
                       {per_addr, per_wdata}, {a, w});
        @(negedge clk);
        req_rd = 1'b0; req_wr = 1'b0;
        if (!legal) begin
            chk(resp_code(rsp_done, rsp_fault) == 2'b01, "R3 narrow write fault",
                resp_code(rsp_done, rsp_fault), 2'b01);
        end else begin
            for (int k = 1; k <= TMO + 1; k++) begin
                if (kind == 2 && k == TMO + 1) begin
                    chk(resp_code(rsp_done, rsp_fault) == 2'b01, "R7 timeout fault",
                        resp_code(rsp_done, rsp_fault), 2'b01);
                    break;
                end
                quiet("R10 no early response");
                if (kind != 2 && k == lat) begin
                    if (kind != 1) per_ack[who] = 1'b1;
                    if (kind != 0) per_err[who] = 1'b1;
                    per_rdata = d;
                    @(negedge clk);
                    per_ack = '0; per_err = '0; per_rdata = '0;
                    if (kind == 0) begin
                        chk(resp_code(rsp_done, rsp_fault) == 2'b10,
                            (lat == TMO) ? "R7 late ack completes" : "R4 ack done",
                            resp_code(rsp_done, rsp_fault), 2'b10);
                        chk(rsp_rdata == (isrd ? or_slices(d) : '0), "R5 read data",
                            rsp_rdata, isrd ? or_slices(d) : '0);
                    end else begin
                        chk(resp_code(rsp_done, rsp_fault) == 2'b01, "R6 error fault",
                            resp_code(rsp_done, rsp_fault), 2'b01);
                    end
                    break;
                end
                @(negedge clk);
            end
        end
        @(negedge clk);
        quiet("R10 single response");
    endtask

    initial begin
        void'($urandom(32'd20240517));
        #3;
        quiet("R1 reset outputs");
        chk(!per_rd && !per_wr, "R1 reset strobes", {per_rd, per_wr}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        quiet("R1 after release");
        xfer(1'b1, 2'd2, 0, 1);           // R1: first request accepted
        xfer(1'b0, 2'd0, 0, 1);           // R3 byte write
        xfer(1'b0, 2'd1, 0, 1);           // R3 half write
        xfer(1'b0, 2'd3, 0, 1);           // R3 reserved size
        xfer(1'b1, 2'd0, 0, 2);           // R2 byte read is legal
        xfer(1'b0, 2'd2, 0, 3);           // R4 write done, R5 zero data
        xfer(1'b1, 2'd2, 0, TMO);         // R7 ack in last window cycle
        xfer(1'b1, 2'd2, 1, 4);           // R6 error
        xfer(1'b0, 2'd2, 3, 2);           // R6 error beats ack
        xfer(1'b1, 2'd2, 2, 0);           // R7 timeout
        xfer(1'b1, 2'd2, 0, TMO);         // R8 full window after timeout
        xfer(1'b0, 2'd2, 2, 0);           // R8 timeout back to back
        // R9: stray pulses while idle
        @(negedge clk);
        per_ack = '1; per_err = '1; per_rdata = '1;
        @(negedge clk);
        per_ack = '0; per_err = '0; per_rdata = '0;
        quiet("R9 idle pulses ignored");
        @(negedge clk);
        quiet("R9 idle pulses ignored later");
        // R10: request during WAIT is dropped
        @(negedge clk);
        req_rd = 1'b1; req_size = 2'd2;
        @(negedge clk);
        req_rd = 1'b0; req_wr = 1'b1; req_size = 2'd2;
        #1;
        chk(!per_wr && !per_rd, "R10 busy request not forwarded", {per_rd, per_wr}, 0);
        @(negedge clk);
        req_wr = 1'b0;
        per_ack[0] = 1'b1;
        @(negedge clk);
        per_ack = '0;
        chk(resp_code(rsp_done, rsp_fault) == 2'b10, "R10 original completes",
            resp_code(rsp_done, rsp_fault), 2'b10);
        repeat (2) begin
            @(negedge clk);
            quiet("R10 dropped request unanswered");
        end
        // random mix
        for (int i = 0; i < 300; i++) begin
            xfer($urandom_range(1, 0), 2'($urandom_range(3, 0)),
                 $urandom_range(3, 0), $urandom_range(TMO, 1));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule